// File: doc/BRIEF.md
# Digital Regulator Training and Restore Controller

This block is the digital half of a mixed analog/digital supply regulator. Each clock it takes a comparator decision ("regulated output is above the selected reference") and steps a saturating up/down code counter. The counter code drives an array of pass transistors, one bit per enable. After reset it runs a training sweep. The reference select climbs from the lowest level to the highest, one level at a time. For each level, the code the loop settles at is stored in a small table.

Once trained, the controller serves a setpoint index. It fetches the stored code for that level, preloads the counter with it and drives the matching reference select. When the comparator reports the output above the reference, it hands regulation to the analog loop. A setpoint change or a wake from sleep repeats this fetch-and-preload, so the output jumps straight to the learned code. The analog loop then only has to trim the remaining error. In sleep all pass devices are off.

States and transitions: TRAIN (step the counter; go to RECORD once the level has settled), RECORD (write the code for the level; go to TRAIN at the next level, or to FETCH and raise the trained flag after the top level), FETCH (read the table for the target) to LOAD (preload the counter) to ENGAGE. ENGAGE steps the counter up while the comparator is low and goes to ANALOG when it is high. From ENGAGE or ANALOG, a sleep request goes to SLEEP, and a new clamped setpoint goes to FETCH. SLEEP goes to FETCH on a wake request.

Top module: `ldo_train_ctrl`

## Requirements
- R1: In TRAIN the code steps by one every cycle, up when `cmp_hi` is 0 and down when it is 1. In ENGAGE it steps up by one each cycle while `cmp_hi` is 0.
- R2: The code saturates at all-zeros when stepping down and at all-ones when stepping up. It never wraps.
- R3: Reset gives code 0, `analog_en` 0, `trained` 0 and `ref_sel` 0. `analog_en` stays 0 for as long as `trained` is 0.
- R4: During training `ref_sel` takes every value from 0 to LEVELS-1 in ascending order, one step at a time.
- R5: A level counts as settled in the cycle in which `cmp_hi` has differed from its value of the previous cycle for SETTLE_N consecutive cycles. The code after that cycle's step is stored for that level, and it is the code later restored for that level.
- R6: The switch to ANALOG happens only from ENGAGE with `cmp_hi` at 1. The code is held constant for as long as `analog_en` is 1.
- R7: When the clamped setpoint differs from the current target in ENGAGE or ANALOG, `analog_en` is 0 one cycle later. If `cmp_hi` is 1 at the preloaded code, `analog_en` is 1 again after four cycles, with the stored code for the new level on `code` and the new level on `ref_sel`.
- R8: A sleep request in ENGAGE or ANALOG gives `code` 0 and `analog_en` 0 one cycle later. `trained` stays 1 through sleep. A setpoint change during sleep changes neither `code` nor `ref_sel`.
- R9: A wake request in SLEEP restores the stored code for the clamped setpoint, with the same timing as R7. A wake request outside SLEEP has no effect.
- R10: A setpoint index of LEVELS or more is treated as LEVELS-1.
- R11: A setpoint change that leaves the clamped index unchanged starts no restore. `analog_en` stays 1 and the code is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_hi | input | 1 | Comparator decision: 1 when the output is above the reference |
| setpoint | input | LVL_W+1 | Requested reference level index (clamped) |
| sleep_req | input | 1 | Enter sleep (honoured in ENGAGE/ANALOG) |
| wake_req | input | 1 | Leave sleep with a restore (honoured in SLEEP) |
| ref_sel | output | LVL_W | Selected digital reference level |
| code | output | CODE_W | Pass-transistor enable code |
| analog_en | output | 1 | 1 selects analog regulation, 0 digital |
| trained | output | 1 | Training sweep complete |

## Verification
The bench builds the block with CODE_W=4, LEVELS=4 and SETTLE_N=2. A 4-bit code reaches both saturation limits within a few cycles. Four levels let the bench cover the complete sweep and every in-range and out-of-range value of the 3-bit setpoint. The bench models the regulator as a comparator that goes high when the code reaches 3+3×level. With this model the learned code for each level can be worked out exactly, and the bench checks each restore against that value, cycle by cycle.

// File: rtl/ldo_train_pkg.sv
package ldo_train_pkg;
    typedef enum logic [2:0] {
        ST_TRAIN,
        ST_RECORD,
        ST_FETCH,
        ST_LOAD,
        ST_ENGAGE,
        ST_ANALOG,
        ST_SLEEP
    } ctrl_state_t;
endpackage

// File: rtl/ldo_code_counter.sv
module ldo_code_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         dir_up,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else if (step_en) begin
            if (dir_up && cnt != MAXV) cnt <= cnt + W'(1);
            else if (!dir_up && cnt != '0) cnt <= cnt - W'(1);
        end
    end

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && dir_up && !load_en && cnt == MAXV) |=> cnt == MAXV); // R2
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !dir_up && !load_en && cnt == '0) |=> cnt == '0); // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && dir_up && !load_en && cnt != MAXV) |=> cnt == $past(cnt) + W'(1)); // R1
endmodule

// File: rtl/ldo_settle_det.sv
module ldo_settle_det #(
    parameter int SETTLE_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cmp,
    output logic settled
);
    localparam int TW = $clog2(SETTLE_N + 1);

    logic          prev;
    logic [TW-1:0] tcnt;
    logic          toggle;

    assign toggle  = cmp != prev;
    assign settled = !clr && toggle && (tcnt == TW'(SETTLE_N - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
            tcnt <= '0;
        end else begin
            prev <= cmp;
            if (clr || !toggle) tcnt <= '0;
            else if (tcnt < TW'(SETTLE_N)) tcnt <= tcnt + TW'(1);
        end
    end

    AST_SETTLE_NEEDS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> (cmp != $past(cmp))); // R5
endmodule

// File: rtl/ldo_code_table.sv
module ldo_code_table #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_q
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rd_q <= '0;
        end else begin
            if (wr_en) mem[wr_idx] <= wr_data;
            rd_q <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/ldo_train_ctrl.sv
module ldo_train_ctrl
    import ldo_train_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int LEVELS   = 16,
    parameter int SETTLE_N = 4,
    parameter int LVL_W    = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_hi,
    input  logic [LVL_W:0]    setpoint,
    input  logic              sleep_req,
    input  logic              wake_req,
    output logic [LVL_W-1:0]  ref_sel,
    output logic [CODE_W-1:0] code,
    output logic              analog_en,
    output logic              trained
);
    localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

    ctrl_state_t       state, nxt;
    logic [LVL_W-1:0]  lvl, tgt, sp_clamp;
    logic [CODE_W-1:0] cnt, rd_q;
    logic              settled, step_en, load_en, wr_en, clr_settle, sp_moved;

    assign sp_clamp = (setpoint > (LVL_W+1)'(LEVELS - 1)) ? LAST : setpoint[LVL_W-1:0];
    assign sp_moved = sp_clamp != tgt;

    ldo_code_counter #(.W(CODE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .dir_up(!cmp_hi),
        .load_en(load_en), .load_val(rd_q), .cnt(cnt)
    );

    ldo_settle_det #(.SETTLE_N(SETTLE_N)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(clr_settle), .cmp(cmp_hi), .settled(settled)
    );

    ldo_code_table #(.DEPTH(LEVELS), .W(CODE_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(lvl), .wr_data(cnt),
        .rd_idx(tgt), .rd_q(rd_q)
    );

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_TRAIN:  if (settled) nxt = ST_RECORD;
            ST_RECORD: nxt = (lvl == LAST) ? ST_FETCH : ST_TRAIN;
            ST_FETCH:  nxt = ST_LOAD;
            ST_LOAD:   nxt = ST_ENGAGE;
            ST_ENGAGE: begin
                if (sleep_req)     nxt = ST_SLEEP;
                else if (sp_moved) nxt = ST_FETCH;
                else if (cmp_hi)   nxt = ST_ANALOG;
            end
            ST_ANALOG: begin
                if (sleep_req)     nxt = ST_SLEEP;
                else if (sp_moved) nxt = ST_FETCH;
            end
            ST_SLEEP:  if (wake_req) nxt = ST_FETCH;
            default:   nxt = ST_TRAIN;
        endcase
    end

    // state register and level bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_TRAIN;
            lvl     <= '0;
            tgt     <= '0;
            trained <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_RECORD) begin
                if (lvl == LAST) trained <= 1'b1;
                else             lvl <= lvl + LVL_W'(1);
            end
            if (nxt == ST_FETCH) tgt <= sp_clamp;
        end
    end

    // outputs and datapath controls
    always_comb begin
        step_en    = 1'b0;
        load_en    = 1'b0;
        wr_en      = 1'b0;
        clr_settle = 1'b1;
        unique case (state)
            ST_TRAIN: begin
                step_en    = 1'b1;
                clr_settle = 1'b0;
            end
            ST_RECORD: wr_en   = 1'b1;
            ST_LOAD:   load_en = 1'b1;
            ST_ENGAGE: step_en = !cmp_hi && !sleep_req && !sp_moved;
            default: ;
        endcase
        ref_sel   = trained ? tgt : lvl;
        code      = (state == ST_SLEEP) ? '0 : cnt;
        analog_en = state == ST_ANALOG;
    end

    AST_TRAIN_DIGITAL: assert property (@(posedge clk) disable iff (!rst_n)
        !trained |-> !analog_en); // R3
    AST_SWEEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        !trained |=> (trained || ref_sel >= $past(ref_sel))); // R4
    AST_HANDOFF_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(analog_en) |-> $past(cmp_hi)); // R6
    AST_ANALOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        analog_en |=> (!analog_en || $stable(code))); // R6
    AST_TRAINED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        trained |=> trained); // R8
    AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (analog_en && sleep_req) |=> (code == '0 && !analog_en)); // R8
endmodule

// File: tb/ldo_train_ctrl_tb.sv
module ldo_train_ctrl_tb;
    localparam int CW = 4;
    localparam int NL = 4;
    localparam int LW = 2;
    localparam time CYC = 5ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          force_en = 1'b1, force_val = 1'b1;
    logic [LW:0]   setpoint = 3'd1;
    logic          sleep_req = 1'b0, wake_req = 1'b0;
    logic [LW-1:0] ref_sel;
    logic [CW-1:0] code;
    logic          analog_en, trained, cmp_hi;

    int n_run = 0, n_fail = 0;
    int mon_bad = 0, mon_analog = 0, mon_levels = 1;
    int last_ref = 0;

    always #(CYC/2) clk = ~clk;

    function automatic int thr(int l);
        return 3 + 3 * l;
    endfunction

    function automatic int clampi(int s);
        return (s >= NL) ? NL - 1 : s;
    endfunction

    assign cmp_hi = force_en ? force_val : (int'(code) >= thr(int'(ref_sel)));

    ldo_train_ctrl #(.CODE_W(CW), .LEVELS(NL), .SETTLE_N(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .setpoint(setpoint),
        .sleep_req(sleep_req), .wake_req(wake_req), .ref_sel(ref_sel),
        .code(code), .analog_en(analog_en), .trained(trained)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // training monitor
    always @(negedge clk) begin
        if (rst_n && !trained) begin
            if (analog_en) mon_analog++;
            if (int'(ref_sel) != last_ref) begin
                if (int'(ref_sel) != last_ref + 1) mon_bad++;
                mon_levels++;
                last_ref = int'(ref_sel);
            end
        end
    end

    initial begin
        #(CYC * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cur, cl, wt;
        int seq [10] = '{0, 4, 1, 5, 2, 6, 0, 7, 3, 2};
        tick(3);
        check(code == 0, "R3 reset code", code, 0);
        check(!analog_en, "R3 reset analog_en", analog_en, 0);
        check(!trained, "R3 reset trained", trained, 0);
        check(ref_sel == 0, "R3 reset ref_sel", ref_sel, 0);
        rst_n = 1'b1;
        tick(5);
        check(code == 0, "R2 low saturation", code, 0);
        force_en = 1'b0;
        wt = 0;
        while (!trained && wt < 1000) begin tick(); wt++; end
        check(trained == 1'b1, "R4 training completes", trained, 1);
        check(mon_bad == 0, "R4 ascending single steps", mon_bad, 0);
        check(mon_levels == NL, "R4 levels visited", mon_levels, NL);
        check(mon_analog == 0, "R3 analog off in training", mon_analog, 0);
        tick(3);
        check(analog_en, "R6 handoff after training", analog_en, 1);
        check(code == thr(1), "R5 learned code level 1", code, thr(1));
        check(ref_sel == 1, "R7 ref_sel after training", ref_sel, 1);
        cur = 1;
        for (int i = 0; i < 10; i++) begin
            cl = clampi(seq[i]);
            setpoint = 3'(seq[i]);
            if (cl != cur) begin
                tick();
                check(!analog_en, "R7 analog drops on change", analog_en, 0);
                tick(3);
                check(analog_en, "R7 analog back after restore", analog_en, 1);
                check(code == thr(cl), "R5 restored code", code, thr(cl));
                check(ref_sel == cl, seq[i] >= NL ? "R10 clamped ref_sel" : "R7 ref_sel",
                      ref_sel, cl);
            end else begin
                tick(4);
                check(analog_en, "R11 no restore analog", analog_en, 1);
                check(code == thr(cl), "R11 code unchanged", code, thr(cl));
            end
            cur = cl;
            tick(2);
        end
        // high saturation while tracking up in ENGAGE
        force_en = 1'b1;
        force_val = 1'b0;
        setpoint = 3'd0;
        tick(3);
        check(code == thr(0), "R1 preload before tracking", code, thr(0));
        for (int k = 1; k <= 12; k++) begin
            tick();
            check(int'(code) == ((3 + k > 15) ? 15 : 3 + k), "R1 step up", code,
                  (3 + k > 15) ? 15 : 3 + k);
        end
        tick(5);
        check(code == 15, "R2 high saturation", code, 15);
        check(!analog_en, "R6 digital while cmp low", analog_en, 1'b0);
        force_val = 1'b1;
        tick();
        check(analog_en, "R6 handoff on cmp high", analog_en, 1);
        check(code == 15, "R6 code held", code, 15);
        force_en = 1'b0;
        tick(2);
        // sleep
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        check(code == 0, "R8 sleep code", code, 0);
        check(!analog_en, "R8 sleep analog_en", analog_en, 0);
        check(trained, "R8 trained kept", trained, 1);
        setpoint = 3'd2;
        tick(6);
        check(code == 0, "R8 setpoint ignored code", code, 0);
        check(ref_sel == 0, "R8 setpoint ignored ref_sel", ref_sel, 0);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        check(!analog_en, "R9 restoring", analog_en, 0);
        tick(3);
        check(analog_en, "R9 analog after wake", analog_en, 1);
        check(code == thr(2), "R9 wake restored code", code, thr(2));
        check(ref_sel == 2, "R9 wake ref_sel", ref_sel, 2);
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        tick(3);
        check(analog_en, "R9 stray wake analog", analog_en, 1);
        check(code == thr(2), "R9 stray wake code", code, thr(2));
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule